// File: doc/BRIEF.md
# Multi-Channel PWM Timer Bank

The block holds a parameterised set of independent PWM timer channels (eight by default) behind a single-cycle register bus. Each channel owns a 16-bit up-counter, a duty compare value, a period compare value and a three-bit control word. While a channel runs, its pin holds a programmable initial level until the count reaches the duty value. The pin then takes the opposite level until the count reaches the period value, and the counter then wraps to zero.

Channels are started and stopped through two shared registers. Each bit of the start register sets the run state of one channel, and each bit of the stop register clears it. A third shared register reads back the run state of every channel. Each channel's control word selects what a stop does. An abrupt stop freezes the counter and returns the pin to its initial level at once. A graceful stop lets the current period finish, parks the counter at zero and then halts. Software may overwrite a counter at any time, for example to zero it before loading a new setting.

The bus is a plain write strobe with word address and data. Reads are combinational from the address.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads zero, every channel is stopped and every `pwm_out` bit is 0.
- R2: Channel n's registers are at word addresses 4n+k. k=0 is the control word: bit 0 is the pin enable, bit 1 is the initial level (1 = high) and bit 2 selects an abrupt stop. Only these three bits read back. k=1 is duty, k=2 is period and k=3 is count, each 16 bits. Written values read back unchanged.
- R3: Writing the start register (address 4·NUM_CH) sets the run state of every channel whose data bit is 1. Zero bits change nothing. The status register (address 4·NUM_CH+2) reads the run state with bit n for channel n.
- R4: A running counter advances by one per clock. A stopped counter holds its value.
- R5: On the clock after the count equals the period value, the counter is 0 and the pin is back at its initial level.
- R6: Once started from count 0, the pin is at the initial level for counts 0 through duty. It is at the opposite level for counts duty+1 through period.
- R7: With duty greater than or equal to period, the pin never leaves its initial level.
- R8: The initial-level bit sets the polarity. With the bit set, the pin is high for counts 0..duty and low afterwards.
- R9: With the pin-enable bit clear, the pin is 0 whatever the counter does.
- R10: Writing 1 to bit n of the stop register (address 4·NUM_CH+1) with the abrupt bit set stops channel n on that clock. The count holds the value it had at that edge and the pin returns to its initial level.
- R11: With the abrupt bit clear, a stop request lets the counter run up to the period value. The status bit stays 1 meanwhile. The counter then wraps to 0 and halts with the pin at its initial level.
- R12: A software count write takes effect on the next clock, even over a period-match wrap on the same edge. It restarts the phase at the initial level, so the pin changes again only after a later duty match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pwm_out | output | NUM_CH | One PWM pin per channel |

## Verification
A software write to a counter can land on the same edge as that counter's period-match wrap. Both want to load the counter. The bench starts a channel, counts clocks so that the count write strobes while the count equals the period, and then reads the counter back. It must hold the written value and not zero, and the pin must sit at its initial level for the rest of that period. A graceful stop is judged the same way: the status bit must stay up exactly until the wrap edge and drop on it.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // sub-register selector inside one channel's four-word window
   typedef enum logic [1:0] {
      SUB_CTRL   = 2'd0,
      SUB_DUTY   = 2'd1,
      SUB_PERIOD = 2'd2,
      SUB_COUNT  = 2'd3
   } sub_reg_e;

   // offsets of the shared registers after the last channel window
   localparam int SHR_START = 0;
   localparam int SHR_STOP  = 1;
   localparam int SHR_STAT  = 2;

   localparam int CTRL_W = 3;

   typedef struct packed {
      logic abrupt;     // bit 2
      logic init_high;  // bit 1
      logic out_en;     // bit 0
   } chan_ctrl_t;

endpackage

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_duty,
   input  logic             wr_period,
   input  logic             wr_count,
   input  logic [CNT_W-1:0] wdata,
   input  logic             start,
   input  logic             stop,
   output chan_ctrl_t       ctrl_q,
   output logic [CNT_W-1:0] duty_q,
   output logic [CNT_W-1:0] period_q,
   output logic [CNT_W-1:0] count_q,
   output logic             run_q,
   output logic             pin
);

   logic phase_q;
   logic drain_q;
   logic at_end;
   logic duty_hit;
   logic level;

   assign at_end   = (count_q == period_q);
   assign duty_hit = (count_q == duty_q) && (duty_q <= period_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         duty_q   <= '0;
         period_q <= '0;
         count_q  <= '0;
         run_q    <= 1'b0;
         phase_q  <= 1'b0;
         drain_q  <= 1'b0;
      end else begin
         if (wr_ctrl)   ctrl_q   <= chan_ctrl_t'(wdata[CTRL_W-1:0]);
         if (wr_duty)   duty_q   <= wdata;
         if (wr_period) period_q <= wdata;

         // counting: a software write outranks the wrap
         if (wr_count) begin
            count_q <= wdata;
            phase_q <= 1'b0;
         end else if (run_q) begin
            if (at_end) begin
               count_q <= '0;
               phase_q <= 1'b0;
               if (drain_q) begin
                  run_q   <= 1'b0;
                  drain_q <= 1'b0;
               end
            end else begin
               count_q <= count_q + 1'b1;
               if (duty_hit) phase_q <= 1'b1;
            end
         end

         // run control
         if (start) begin
            run_q   <= 1'b1;
            drain_q <= 1'b0;
         end else if (stop) begin
            if (ctrl_q.abrupt) begin
               run_q   <= 1'b0;
               drain_q <= 1'b0;
               phase_q <= 1'b0;
               count_q <= count_q;
            end else if (run_q) begin
               drain_q <= 1'b1;
            end
         end
      end
   end

   assign level = ctrl_q.out_en & (ctrl_q.init_high ^ phase_q);

   generate
      if (OUT_REG) begin : g_pin_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin <= 1'b0;
            else        pin <= level;
         end
      end else begin : g_pin_comb
         assign pin = level;
      end
   endgenerate

endmodule

// File: rtl/pwm_rd_mux.sv
module pwm_rd_mux
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  chan_ctrl_t        ctrl_a   [NUM_CH],
   input  logic [CNT_W-1:0]  duty_a   [NUM_CH],
   input  logic [CNT_W-1:0]  period_a [NUM_CH],
   input  logic [CNT_W-1:0]  count_a  [NUM_CH],
   input  logic [NUM_CH-1:0] run_v,
   output logic [DATA_W-1:0] rdata
);

   localparam int SHR_BASE = NUM_CH * 4;

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(i*4 + int'(SUB_CTRL)))   rdata = DATA_W'(ctrl_a[i]);
         if (addr == ADDR_W'(i*4 + int'(SUB_DUTY)))   rdata = DATA_W'(duty_a[i]);
         if (addr == ADDR_W'(i*4 + int'(SUB_PERIOD))) rdata = DATA_W'(period_a[i]);
         if (addr == ADDR_W'(i*4 + int'(SUB_COUNT)))  rdata = DATA_W'(count_a[i]);
      end
      if (addr == ADDR_W'(SHR_BASE + SHR_STAT)) rdata = DATA_W'(run_v);
   end

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 6,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int SHR_BASE = NUM_CH * 4;
   localparam logic [ADDR_W-1:0] A_START = ADDR_W'(SHR_BASE + SHR_START);
   localparam logic [ADDR_W-1:0] A_STOP  = ADDR_W'(SHR_BASE + SHR_STOP);

   initial begin
      assert (DATA_W >= CNT_W)  else $error("DATA_W narrower than counter");
      assert (DATA_W >= NUM_CH) else $error("DATA_W narrower than channel count");
      assert (CNT_W >= CTRL_W)  else $error("CNT_W narrower than control word");
      assert (SHR_BASE + SHR_STAT < (1 << ADDR_W)) else $error("ADDR_W too small");
   end

   chan_ctrl_t        ctrl_a   [NUM_CH];
   logic [CNT_W-1:0]  duty_a   [NUM_CH];
   logic [CNT_W-1:0]  period_a [NUM_CH];
   logic [CNT_W-1:0]  count_a  [NUM_CH];
   logic [NUM_CH-1:0] run_v;
   logic [NUM_CH-1:0] wr_ctrl_v, wr_duty_v, wr_per_v, wr_cnt_v;
   logic [NUM_CH-1:0] start_v, stop_v;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(i*4);

         assign wr_ctrl_v[i] = bus_we && (bus_addr == A_BASE + ADDR_W'(SUB_CTRL));
         assign wr_duty_v[i] = bus_we && (bus_addr == A_BASE + ADDR_W'(SUB_DUTY));
         assign wr_per_v[i]  = bus_we && (bus_addr == A_BASE + ADDR_W'(SUB_PERIOD));
         assign wr_cnt_v[i]  = bus_we && (bus_addr == A_BASE + ADDR_W'(SUB_COUNT));
         assign start_v[i]   = bus_we && (bus_addr == A_START) && bus_wdata[i];
         assign stop_v[i]    = bus_we && (bus_addr == A_STOP)  && bus_wdata[i];

         pwm_chan #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (wr_ctrl_v[i]),
            .wr_duty  (wr_duty_v[i]),
            .wr_period(wr_per_v[i]),
            .wr_count (wr_cnt_v[i]),
            .wdata    (bus_wdata[CNT_W-1:0]),
            .start    (start_v[i]),
            .stop     (stop_v[i]),
            .ctrl_q   (ctrl_a[i]),
            .duty_q   (duty_a[i]),
            .period_q (period_a[i]),
            .count_q  (count_a[i]),
            .run_q    (run_v[i]),
            .pin      (pwm_out[i])
         );
      end
   endgenerate

   pwm_rd_mux #(
      .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) i_rd_mux (
      .addr    (bus_addr),
      .ctrl_a  (ctrl_a),
      .duty_a  (duty_a),
      .period_a(period_a),
      .count_a (count_a),
      .run_v   (run_v),
      .rdata   (bus_rdata)
   );

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input chan_ctrl_t        ctrl_a   [NUM_CH],
   input logic [CNT_W-1:0]  duty_a   [NUM_CH],
   input logic [CNT_W-1:0]  period_a [NUM_CH],
   input logic [CNT_W-1:0]  count_a  [NUM_CH],
   input logic [NUM_CH-1:0] run_v,
   input logic [NUM_CH-1:0] wr_ctrl_v,
   input logic [NUM_CH-1:0] wr_duty_v,
   input logic [NUM_CH-1:0] wr_per_v,
   input logic [NUM_CH-1:0] wr_cnt_v,
   input logic [NUM_CH-1:0] start_v,
   input logic [NUM_CH-1:0] stop_v,
   input logic [NUM_CH-1:0] pwm_out
);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
         // R4
         hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_v[i] && !wr_cnt_v[i]) |=> $stable(count_a[i]));

         // R5
         wrap_at_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run_v[i] && count_a[i] == period_a[i] && !wr_cnt_v[i]
             && !(stop_v[i] && ctrl_a[i].abrupt)) |=> (count_a[i] == '0));

         // R7
         long_duty_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_a[i].out_en && duty_a[i] > period_a[i]
             && pwm_out[i] == ctrl_a[i].init_high
             && !wr_ctrl_v[i] && !wr_duty_v[i] && !wr_per_v[i] && !wr_cnt_v[i])
            |=> (pwm_out[i] == ctrl_a[i].init_high));

         // R3
         start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start_v[i] |=> run_v[i]);

         // R10
         abrupt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_v[i] && ctrl_a[i].abrupt) |=> !run_v[i]);

         // R11
         graceful_keeps_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_v[i] && !ctrl_a[i].abrupt && run_v[i] && count_a[i] != period_a[i])
            |=> run_v[i]);
      end
   endgenerate

endmodule

bind pwm_timer_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_pwm_bank_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_a   (ctrl_a),
   .duty_a   (duty_a),
   .period_a (period_a),
   .count_a  (count_a),
   .run_v    (run_v),
   .wr_ctrl_v(wr_ctrl_v),
   .wr_duty_v(wr_duty_v),
   .wr_per_v (wr_per_v),
   .wr_cnt_v (wr_cnt_v),
   .start_v  (start_v),
   .stop_v   (stop_v),
   .pwm_out  (pwm_out)
);

// File: tb/test_pwm_timer_bank.sv
module test_pwm_timer_bank;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 20000;
   localparam int A_START    = 32;
   localparam int A_STOP     = 33;
   localparam int A_STAT     = 34;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  pwm_out;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_timer_bank i_pwm_timer_bank (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   function automatic int ra(input int ch, input int sub);
      return ch*4 + sub;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      bus_addr = 6'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic setup(input int ch, input logic [15:0] ctl,
                        input logic [15:0] duty, input logic [15:0] per);
      wr(ra(ch,0), ctl);
      wr(ra(ch,1), duty);
      wr(ra(ch,2), per);
      wr(ra(ch,3), 16'h0);
   endtask

   task automatic t_reset;
      logic [15:0] d;
      for (int ch = 0; ch < 8; ch += 7) begin
         for (int s = 0; s < 4; s++) begin
            rd(ra(ch,s), d);
            chk("R1", $sformatf("reg ch%0d sub%0d", ch, s), d, 0);
         end
      end
      rd(A_STAT, d);
      chk("R1", "status", d, 0);
      chk("R1", "pins", pwm_out, 0);
   endtask

   task automatic t_regs;
      logic [15:0] d;
      wr(ra(3,0), 16'hFFFF);
      wr(ra(3,1), 16'h1234);
      wr(ra(3,2), 16'hABCD);
      wr(ra(3,3), 16'h0055);
      rd(ra(3,0), d); chk("R2", "ctrl keeps 3 bits", d, 16'h0007);
      rd(ra(3,1), d); chk("R2", "duty", d, 16'h1234);
      rd(ra(3,2), d); chk("R2", "period", d, 16'hABCD);
      rd(ra(3,3), d); chk("R2", "count", d, 16'h0055);
      repeat (5) @(negedge clk);
      rd(ra(3,3), d); chk("R4", "stopped count holds", d, 16'h0055);
      wr(ra(3,0), 16'h0);
   endtask

   task automatic t_wave;
      logic [15:0] d;
      setup(0, 16'h1, 16'd3, 16'd7);
      wr(A_START, 16'h0001);
      rd(A_STAT, d); chk("R3", "status after start", d, 16'h0001);
      for (int k = 0; k < 20; k++) begin
         rd(ra(0,3), d);
         chk("R4", $sformatf("count step %0d", k), d, 16'(k % 8));
         chk("R6", $sformatf("pin step %0d", k), pwm_out[0], ((k % 8) >= 4) ? 1 : 0);
         if (k % 8 == 0 && k > 0) chk("R5", "wrap to zero at initial level", pwm_out[0], 0);
         @(negedge clk);
      end
      wr(A_START, 16'h0000);
      rd(A_STAT, d); chk("R3", "zero bits leave status", d, 16'h0001);
   endtask

   task automatic t_polarity;
      setup(1, 16'h3, 16'd1, 16'd3);
      wr(A_START, 16'h0002);
      for (int k = 0; k < 10; k++) begin
         chk("R8", $sformatf("inverted pin step %0d", k), pwm_out[1], ((k % 4) >= 2) ? 0 : 1);
         @(negedge clk);
      end
   endtask

   task automatic t_long_duty;
      setup(2, 16'h1, 16'd9, 16'd5);
      wr(A_START, 16'h0004);
      for (int k = 0; k < 14; k++) begin
         chk("R7", $sformatf("duty>period pin step %0d", k), pwm_out[2], 0);
         @(negedge clk);
      end
      wr(ra(2,1), 16'd5);
      wr(ra(2,3), 16'd0);
      for (int k = 0; k < 14; k++) begin
         chk("R7", $sformatf("duty=period pin step %0d", k), pwm_out[2], 0);
         @(negedge clk);
      end
   endtask

   task automatic t_gate;
      setup(4, 16'h2, 16'd1, 16'd3);
      wr(A_START, 16'h0010);
      for (int k = 0; k < 8; k++) begin
         chk("R9", $sformatf("gated pin step %0d", k), pwm_out[4], 0);
         @(negedge clk);
      end
   endtask

   task automatic t_abrupt;
      logic [15:0] d, c;
      setup(5, 16'h5, 16'd0, 16'd9);
      wr(A_START, 16'h0020);
      repeat (4) @(negedge clk);
      chk("R10", "pin active before stop", pwm_out[5], 1);
      rd(ra(5,3), c);
      wr(A_STOP, 16'h0020);
      rd(A_STAT, d); chk("R10", "status bit drops", d[5], 0);
      chk("R10", "pin back to initial", pwm_out[5], 0);
      rd(ra(5,3), d); chk("R10", "count frozen", d, c + 16'd1);
      repeat (5) @(negedge clk);
      rd(ra(5,3), d); chk("R10", "count still frozen", d, c + 16'd1);
   endtask

   task automatic t_graceful;
      logic [15:0] d;
      setup(6, 16'h1, 16'd2, 16'd9);
      wr(A_START, 16'h0040);
      repeat (4) @(negedge clk);
      wr(A_STOP, 16'h0040);
      rd(ra(6,3), d); chk("R11", "count runs on", d, 16'd6);
      rd(A_STAT, d);  chk("R11", "status held", d[6], 1);
      chk("R11", "pin still active", pwm_out[6], 1);
      repeat (3) @(negedge clk);
      rd(ra(6,3), d); chk("R11", "count at period", d, 16'd9);
      rd(A_STAT, d);  chk("R11", "status until wrap", d[6], 1);
      @(negedge clk);
      rd(ra(6,3), d); chk("R11", "parked at zero", d, 16'd0);
      rd(A_STAT, d);  chk("R11", "status dropped", d[6], 0);
      chk("R11", "pin at initial", pwm_out[6], 0);
      repeat (3) @(negedge clk);
      rd(ra(6,3), d); chk("R11", "stays halted", d, 16'd0);
   endtask

   task automatic t_count_write;
      logic [15:0] d;
      setup(7, 16'h1, 16'd1, 16'd5);
      wr(A_START, 16'h0080);
      repeat (4) @(negedge clk);
      chk("R6", "active before collision", pwm_out[7], 1);
      wr(ra(7,3), 16'd2);
      rd(ra(7,3), d); chk("R12", "write beats wrap", d, 16'd2);
      chk("R12", "phase restarted", pwm_out[7], 0);
      @(negedge clk);
      rd(ra(7,3), d); chk("R12", "counts from written value", d, 16'd3);
      chk("R12", "no toggle past duty", pwm_out[7], 0);
      repeat (2) @(negedge clk);
      chk("R12", "initial at period", pwm_out[7], 0);
      repeat (3) @(negedge clk);
      rd(ra(7,3), d); chk("R12", "after wrap count", d, 16'd2);
      chk("R12", "toggles after next duty match", pwm_out[7], 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_wave();
      t_polarity();
      t_long_duty();
      t_gate();
      t_abrupt();
      t_graceful();
      t_count_write();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule